// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel samples. A serial stream has three wires: a bit clock, a word clock that marks which channel the current word belongs to, and a data line. The block presents each received word as a 24-bit value on a left or right output. A one-cycle strobe on that channel marks each new word. All logic runs on one system clock. The bit clock, the word clock and the data line are sampled in that domain, so the system clock must be several times faster than the bit clock.

An 8-bit format input sets how the stream is read, and it can change at run time. The format chooses the clocking role. As a slave, the block follows clocks that are driven from outside. As a master, it divides a system clock of 256 times the frame rate to drive both clocks itself. The format also sets the bit-clock ratio, left or right justification, the word width for right-justified data, a one-bit MSB delay for left-justified data, and the polarity of both clocks.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, both strobes are low, both data outputs are zero and `wclkOut` is low. `bclkOut` is low in slave role and equals format bit 1 in master role.
- R2: With format bit 7 = 0 (slave role), the block takes its clocks from `bclkIn` and `wclkIn`, and holds `bclkOut` and `wclkOut` low.
- R3: With format bit 7 = 1 (master role), the word clock runs at 1/256 of the system clock with 128 cycles high and 128 low. The bit clock has a half period of 2 system cycles when format bit 6 = 0 (64 bits per frame) and 1 cycle when bit 6 = 1 (128 bits per frame). The word clock changes only when `bclkOut` moves to its non-sampling level.
- R4: With format bit 3 = 0 (left-justified), the block returns the first 24 bits of a word, MSB first. The MSB is taken on the first sampling edge after a word-clock change when format bit 2 = 0, and on the second when bit 2 = 1. Later bits of the word are ignored.
- R5: With format bit 3 = 1 (right-justified), the last N bits before the next word-clock change form the word, LSB last. N is 24 for bits[5:4] = 00, 20 for 01 and 16 for 10. Earlier bits are ignored. The result is MSB-aligned with the unused low bits zero.
- R6: Resolution code bits[5:4] = 11 behaves exactly as code 00 (24 bits).
- R7: Format bit 2 has no effect on right-justified reception.
- R8: Format bit 1 = 0 samples data on rising bit-clock edges, and 1 samples on falling edges.
- R9: Format bit 0 = 0 assigns a high word clock to the left channel, and 1 assigns it to the right channel.
- R10: Each complete word raises exactly one one-cycle strobe on its own channel. The two strobes are never high together, and every complete word is delivered.
- R11: The word that is in progress when reception starts is never reported. Output begins with the first word that starts after a detected word-clock change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (256x frame rate in master role) |
| rstN | input | 1 | Active-low synchronous reset |
| fmtCfg | input | 8 | Format: [7] role, [6] ratio, [5:4] resolution, [3] justification, [2] delay, [1] bit-clock polarity, [0] word-clock polarity |
| bclkIn | input | 1 | External bit clock (slave role) |
| wclkIn | input | 1 | External word clock (slave role) |
| sdataIn | input | 1 | Serial data |
| bclkOut | output | 1 | Generated bit clock (master role) |
| wclkOut | output | 1 | Generated word clock (master role) |
| leftData | output | 24 | Last left-channel word, MSB-aligned |
| leftValid | output | 1 | One-cycle strobe for a new left word |
| rightData | output | 24 | Last right-channel word, MSB-aligned |
| rightValid | output | 1 | One-cycle strobe for a new right word |

## Verification
In right-justified mode, a single sampling edge both closes the finished word and shifts in the first bit of the next word under the other channel. The capture must read the shift register before that shift, and it must report the channel that was just completed. The bench provokes this edge case with 24-bit right-justified words sent in 25-bit slots, so every stored bit belongs to the finished word and the random leading bit of the next word sits right at the boundary. It also runs left-justified data with a delay in the same 25-bit slots, which places the capture on the last edge before the word-clock change. Each strobe is judged against per-channel queues of expected words, so a wrong bit order, a wrong channel or a missing word each shows as a mismatch.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  // Format word, MSB first, matching the format input bit positions
  typedef struct packed {
    logic       master;
    logic       ratio128;
    logic [1:0] res;
    logic       rightJust;
    logic       msbDelay;
    logic       bclkFall;
    logic       wclkHighRight;
  } fmt_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic shiftEn;   // sampling edge seen this cycle
    logic bitIn;     // data bit taken on that edge
    logic capEn;     // a word is complete
    logic capLeft;   // channel of the completed word
    logic rjCap;     // completion came from a right-justified boundary
  } rxStrobe_t;

endpackage

// File: rtl/sarx_ctrl.sv
module sarx_ctrl
  import sarx_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int POS_W    = 7,
  parameter int SAMPLE_W = 24
) (
  input  logic      clk,
  input  logic      rstN,
  input  fmt_t      fmt,
  input  logic      bclkIn,
  input  logic      wclkIn,
  input  logic      sdataIn,
  output logic      bclkOut,
  output logic      wclkOut,
  output rxStrobe_t strb
);

  localparam int IDX_64X  = DIV_W - 7;
  localparam int IDX_128X = DIV_W - 8;
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] LJ_LAST = POS_W'(SAMPLE_W - 1);

  logic [DIV_W-1:0] divCnt;
  logic bclkRaw, srcB, srcW;
  logic bclkQ, bclkQd, wclkQ, sdatQ;
  logic seen, wPrev, primed, curLeft;
  logic [POS_W-1:0] pos, tickPos, ljTarget;
  logic tick, wordEdge, capLj, capRj;

  // Master clock generation from the system clock
  always_ff @(posedge clk) begin
    if (!rstN || !fmt.master) divCnt <= '0;
    else                      divCnt <= divCnt + 1'b1;
  end

  assign bclkRaw = fmt.ratio128 ? divCnt[IDX_128X] : divCnt[IDX_64X];
  assign bclkOut = fmt.master ? (bclkRaw ^ fmt.bclkFall) : 1'b0;
  assign wclkOut = fmt.master ? divCnt[DIV_W-1] : 1'b0;

  // One sampling stage shared by both roles keeps clock and data aligned
  assign srcB = fmt.master ? bclkOut : bclkIn;
  assign srcW = fmt.master ? wclkOut : wclkIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkQ  <= 1'b0;
      bclkQd <= 1'b0;
      wclkQ  <= 1'b0;
      sdatQ  <= 1'b0;
    end else begin
      bclkQ  <= srcB;
      bclkQd <= bclkQ;
      wclkQ  <= srcW;
      sdatQ  <= sdataIn;
    end
  end

  assign tick     = (bclkQ != fmt.bclkFall) && (bclkQd == fmt.bclkFall);
  assign wordEdge = tick && seen && (wclkQ != wPrev);

  always_comb begin
    if (wordEdge)            tickPos = '0;
    else if (pos == POS_MAX) tickPos = POS_MAX;
    else                     tickPos = pos + 1'b1;
  end

  assign ljTarget = LJ_LAST + POS_W'(fmt.msbDelay);
  assign capLj    = tick && !fmt.rightJust && (tickPos == ljTarget);
  assign capRj    = wordEdge && fmt.rightJust && primed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seen    <= 1'b0;
      wPrev   <= 1'b0;
      primed  <= 1'b0;
      curLeft <= 1'b0;
      pos     <= POS_MAX;
    end else if (tick) begin
      seen  <= 1'b1;
      wPrev <= wclkQ;
      pos   <= tickPos;
      if (wordEdge) begin
        curLeft <= wclkQ ^ fmt.wclkHighRight;
        primed  <= 1'b1;
      end
    end
  end

  assign strb.shiftEn = tick;
  assign strb.bitIn   = sdatQ;
  assign strb.capEn   = capLj || capRj;
  assign strb.capLeft = curLeft;
  assign strb.rjCap   = capRj;

endmodule

// File: rtl/sarx_datapath.sv
module sarx_datapath
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  fmt_t                fmt,
  input  rxStrobe_t           strb,
  output logic [SAMPLE_W-1:0] leftData,
  output logic                leftValid,
  output logic [SAMPLE_W-1:0] rightData,
  output logic                rightValid
);

  localparam int W_MID   = SAMPLE_W - 4;
  localparam int W_SHORT = SAMPLE_W - 8;

  logic [SAMPLE_W-1:0] shiftReg, rjWord, capWord;

  always_ff @(posedge clk) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[SAMPLE_W-2:0], strb.bitIn};
  end

  // Right-justified words are read before the boundary bit shifts in
  always_comb begin
    case (fmt.res)
      2'b01:   rjWord = {shiftReg[W_MID-1:0],   {(SAMPLE_W-W_MID){1'b0}}};
      2'b10:   rjWord = {shiftReg[W_SHORT-1:0], {(SAMPLE_W-W_SHORT){1'b0}}};
      default: rjWord = shiftReg;
    endcase
  end

  assign capWord = strb.rjCap ? rjWord : {shiftReg[SAMPLE_W-2:0], strb.bitIn};

  for (genvar ch = 0; ch < 2; ch++) begin : gChan
    localparam logic IS_LEFT = (ch == 0);
    logic [SAMPLE_W-1:0] dataQ;
    logic                validQ;
    logic                hit;

    assign hit = strb.capEn && (strb.capLeft == IS_LEFT);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataQ  <= '0;
        validQ <= 1'b0;
      end else begin
        validQ <= hit;
        if (hit) dataQ <= capWord;
      end
    end
  end

  assign leftData   = gChan[0].dataQ;
  assign leftValid  = gChan[0].validQ;
  assign rightData  = gChan[1].dataQ;
  assign rightValid = gChan[1].validQ;

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int POS_W    = 7,
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          fmtCfg,
  input  logic                bclkIn,
  input  logic                wclkIn,
  input  logic                sdataIn,
  output logic                bclkOut,
  output logic                wclkOut,
  output logic [SAMPLE_W-1:0] leftData,
  output logic                leftValid,
  output logic [SAMPLE_W-1:0] rightData,
  output logic                rightValid
);

  fmt_t      fmt;
  rxStrobe_t strb;

  assign fmt = fmt_t'(fmtCfg);

  sarx_ctrl #(
    .DIV_W(DIV_W), .POS_W(POS_W), .SAMPLE_W(SAMPLE_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .fmt(fmt),
    .bclkIn(bclkIn), .wclkIn(wclkIn), .sdataIn(sdataIn),
    .bclkOut(bclkOut), .wclkOut(wclkOut), .strb(strb)
  );

  sarx_datapath #(
    .SAMPLE_W(SAMPLE_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .fmt(fmt), .strb(strb),
    .leftData(leftData), .leftValid(leftValid),
    .rightData(rightData), .rightValid(rightValid)
  );

endmodule

// File: rtl/sarx_chk.sv
module sarx_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic [7:0]          fmtCfg,
  input logic                bclkOut,
  input logic                wclkOut,
  input logic [SAMPLE_W-1:0] leftData,
  input logic                leftValid,
  input logic                rightValid
);

  // R10
  left_strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    leftValid |=> !leftValid);

  // R10
  right_strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rightValid |=> !rightValid);

  // R10
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(leftValid && rightValid));

  // R3
  wclk_on_idle_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fmtCfg[7] && $stable(fmtCfg) && (wclkOut != $past(wclkOut)))
      |-> (bclkOut == fmtCfg[1]));

  // R3
  bclk_64x_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fmtCfg[7] && !fmtCfg[6] && $stable(fmtCfg) && (bclkOut != $past(bclkOut)))
      |=> (bclkOut == $past(bclkOut)));

  // R5
  short_word_zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (leftValid && fmtCfg[3] && (fmtCfg[5:4] == 2'b10) && $stable(fmtCfg))
      |-> (leftData[SAMPLE_W-17:0] == '0));

endmodule

bind serial_audio_rx sarx_chk #(.SAMPLE_W(SAMPLE_W)) i_sarx_chk (
  .clk(clk), .rstN(rstN), .fmtCfg(fmtCfg),
  .bclkOut(bclkOut), .wclkOut(wclkOut),
  .leftData(leftData), .leftValid(leftValid), .rightValid(rightValid)
);

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  fmtCfg;
  logic        bclkIn, wclkIn, sdataIn;
  logic        bclkOut, wclkOut;
  logic [23:0] leftData, rightData;
  logic        leftValid, rightValid;

  always #5 clk = ~clk;

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rstN(rstN), .fmtCfg(fmtCfg),
    .bclkIn(bclkIn), .wclkIn(wclkIn), .sdataIn(sdataIn),
    .bclkOut(bclkOut), .wclkOut(wclkOut),
    .leftData(leftData), .leftValid(leftValid),
    .rightData(rightData), .rightValid(rightValid)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  bit    monOn  = 1'b0;
  bit    inPost = 1'b0;
  string curTag = "";
  logic [23:0] expL[$];
  logic [23:0] expR[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expWord(input logic [23:0] s, input logic [7:0] c);
    if (!c[3]) return s;
    case (c[5:4])
      2'b01:   return {s[23:4], 4'b0};
      2'b10:   return {s[23:8], 8'b0};
      default: return s;
    endcase
  endfunction

  function automatic string makeTag(input logic [7:0] c);
    string t;
    t = c[3] ? ((c[5:4] == 2'b11) ? "R6 R5" : "R5") : "R4";
    if (c[3] && c[2]) t = {t, " R7"};
    if (c[1])         t = {t, " R8"};
    if (c[0])         t = {t, " R9"};
    t = {t, c[7] ? " R3" : " R2"};
    return t;
  endfunction

  // Word monitor: compares each strobe with the per-channel expectation
  logic [23:0] eL, eR;
  logic        prevLv = 1'b0, prevRv = 1'b0;
  always @(negedge clk) begin
    if (monOn) begin
      if (leftValid && rightValid) chk("R10 both strobes high", 1, 0);
      if (leftValid && prevLv)     chk("R10 left strobe longer than one cycle", 1, 0);
      if (rightValid && prevRv)    chk("R10 right strobe longer than one cycle", 1, 0);
      if (leftValid) begin
        if (expL.size() > 0) begin
          eL = expL.pop_front();
          chk({curTag, " left word"}, {8'h0, leftData}, {8'h0, eL});
        end else if (!inPost) chk("R11 unexpected left word", 1, 0);
      end
      if (rightValid) begin
        if (expR.size() > 0) begin
          eR = expR.pop_front();
          chk({curTag, " right word"}, {8'h0, rightData}, {8'h0, eR});
        end else if (!inPost) chk("R11 unexpected right word", 1, 0);
      end
    end
    prevLv = leftValid;
    prevRv = rightValid;
  end

  task automatic pulseReset(input logic [7:0] c);
    rstN   = 1'b0;
    fmtCfg = c;
    bclkIn = c[1];
    wclkIn = 1'b0;
    sdataIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 left strobe in reset", leftValid, 0);
    chk("R1 wclkOut in reset", wclkOut, 0);
    chk("R1 bclkOut in reset", bclkOut, c[7] ? c[1] : 1'b0);
    rstN = 1'b1;
  endtask

  task automatic runStream(input logic [7:0] c, input int nWords, input int bpwSlave);
    int bpw, halfCnt, bitPos, wordCnt, bitIdx, guard, n, off, k;
    logic pol, bc, wc, prevBc, prevWc, chLeft;
    logic [23:0] s;
    logic [63:0] wbits;
    bpw = c[7] ? (c[6] ? 64 : 32) : bpwSlave;
    pol = c[1];
    halfCnt = 0; bitPos = 0; wordCnt = 0; bitIdx = 0; guard = 0;
    wbits = '0;
    inPost = 1'b0;
    bclkIn = pol;
    wclkIn = 1'($urandom % 2);
    @(negedge clk);
    prevBc = c[7] ? bclkOut : bclkIn;
    prevWc = c[7] ? wclkOut : wclkIn;
    while (wordCnt < nWords + 2 && guard < 40000) begin
      @(negedge clk);
      guard++;
      if (!c[7]) begin
        halfCnt++;
        if (halfCnt == 2) begin
          halfCnt = 0;
          if (bclkIn == pol) bclkIn = ~pol;
          else begin
            bclkIn = pol;
            bitPos++;
            if (bitPos == bpw) begin
              bitPos = 0;
              wclkIn = ~wclkIn;
            end
          end
        end
      end
      bc = c[7] ? bclkOut : bclkIn;
      wc = c[7] ? wclkOut : wclkIn;
      if (bc == pol && prevBc != pol) begin
        if (wc != prevWc) begin
          wordCnt++;
          bitIdx = 0;
          prevWc = wc;
          s = 24'($urandom);
          n = (c[3] && c[5:4] == 2'b01) ? 20 : (c[3] && c[5:4] == 2'b10) ? 16 : 24;
          off = bpw - n;
          for (int j = 0; j < 64; j++) begin
            wbits[j] = 1'($urandom % 2);
            if (j < bpw) begin
              if (!c[3]) begin
                k = j - int'(c[2]);
                if (k >= 0 && k < 24) wbits[j] = s[23-k];
              end else if (j >= off) begin
                wbits[j] = s[23-(j-off)];
              end
            end
          end
          if (wordCnt <= nWords) begin
            chLeft = wc ^ c[0];
            if (chLeft) expL.push_back(expWord(s, c));
            else        expR.push_back(expWord(s, c));
          end else inPost = 1'b1;
        end
        sdataIn = wbits[bitIdx];
        if (bitIdx < 63) bitIdx++;
      end
      prevBc = bc;
    end
  endtask

  task automatic doTest(input logic [7:0] c, input int bpwS);
    int cnt;
    logic b0;
    curTag = makeTag(c);
    pulseReset(c);
    if (c[7]) begin
      b0 = bclkOut;
      while (bclkOut == b0) @(negedge clk);
      b0 = bclkOut;
      cnt = 0;
      while (bclkOut == b0) begin @(negedge clk); cnt++; end
      chk("R3 bit clock half period", cnt, c[6] ? 1 : 2);
      while (wclkOut != 1'b1) @(negedge clk);
      cnt = 0;
      while (wclkOut == 1'b1) begin @(negedge clk); cnt++; end
      chk("R3 word clock high time", cnt, 128);
      cnt = 0;
      while (wclkOut == 1'b0) begin @(negedge clk); cnt++; end
      chk("R3 word clock low time", cnt, 128);
      pulseReset(c);
    end
    monOn = 1'b1;
    runStream(c, 6, bpwS);
    repeat (30) @(negedge clk);
    monOn = 1'b0;
    chk({"R10 all left words delivered ", curTag}, expL.size(), 0);
    chk({"R10 all right words delivered ", curTag}, expR.size(), 0);
    if (!c[7]) begin
      chk("R2 bclkOut held low in slave role", bclkOut, 0);
      chk("R2 wclkOut held low in slave role", wclkOut, 0);
    end
    expL.delete();
    expR.delete();
  endtask

  initial begin
    logic [7:0] rc;
    void'($urandom(32'd7321));
    rstN = 1'b0; fmtCfg = 8'h00; bclkIn = 1'b0; wclkIn = 1'b0; sdataIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 left strobe after reset", leftValid, 0);
    chk("R1 right strobe after reset", rightValid, 0);
    chk("R1 left data after reset", {8'h0, leftData}, 0);
    chk("R1 right data after reset", {8'h0, rightData}, 0);
    chk("R1 bclkOut after reset", bclkOut, 0);
    chk("R1 wclkOut after reset", wclkOut, 0);

    doTest(8'h00, 32);   // left-justified, no delay
    doTest(8'h04, 25);   // delayed MSB, capture on the last slot edge
    doTest(8'h08, 25);   // 24-bit right-justified in a tight slot
    doTest(8'h18, 32);   // 20-bit
    doTest(8'h28, 32);   // 16-bit
    doTest(8'h38, 32);   // reserved code
    doTest(8'h2C, 32);   // delay ignored when right-justified
    doTest(8'h02, 32);   // falling-edge sampling
    doTest(8'h01, 32);   // word-clock polarity swapped
    doTest(8'h80, 32);   // master 64x
    doTest(8'hC4, 32);   // master 128x with delay
    doTest(8'hA9, 32);   // master right-justified 16-bit
    doTest(8'hFF, 32);
    for (int t = 0; t < 12; t++) begin
      rc = 8'($urandom);
      doTest(rc, ($urandom % 2) ? 32 : 25);
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule